// File: doc/BRIEF.md
# Infrared Receive Byte Queue with Interrupt Flags

This block sits between an infrared sampler and a processor bus. The sampler hands it run-length bytes one per cycle (`smp_valid` with `smp_byte`). It also pulses `smp_pkt_end` when the line has gone idle. The bytes are held in a first-in first-out store whose depth is a parameter, normally 16 or 64. Software drains the store through a small word-addressed register file. One read of the data word pops exactly one byte.

Three pending flags are kept:

- An overflow flag, set when a byte arrives while the store is full.
- A packet-end flag, set by the sampler's pulse.
- A level-driven data-available flag, raised while the fill exceeds a programmable level.

Each flag is cleared by writing a one to its bit in the status word. The status word also carries the current fill count. A single interrupt line is high while any pending flag has its enable bit set. Software normally programs the level to half the depth minus one. It then reads the status on each interrupt and pops as many bytes as the count field reports.

Register reads are registered. `reg_rdata` presents the result of a read in the cycle after `reg_rd` is asserted, and holds it until the next read. Word addresses: 0 is the data word, 1 is the enable word, 2 is the status word, and 3 reads as zero.

Top module: `ir_rx_fifo_regs`

## Requirements
- R1: After synchronous reset, the status word, the enable word and `reg_rdata` read as zero, and `irq` is low.
- R2: Each read of the data word (address 0) returns the oldest held byte in bits 7:0, with bits 31:8 zero, and removes it; bytes come out in the order they were pushed.
- R3: Status word (address 2) bits starting at 8, of width log2(DEPTH)+1, hold the number of bytes currently stored, from 0 up to DEPTH.
- R4: A push while the store holds DEPTH bytes and no pop happens in the same cycle drops the byte, sets the overflow flag (status bit 0) and leaves stored contents and order unchanged.
- R5: A data read while the store is empty returns zero and changes neither the count nor the pointers, so the next pushed byte is the next one read.
- R6: A one-cycle pulse on `smp_pkt_end` sets the packet-end flag (status bit 1).
- R7: The data-available flag (status bit 4) is set in every cycle in which the fill count is greater than the level field (enable word bits from 8, width log2(DEPTH)+1); while that holds, a write-one-to-clear does not leave it cleared.
- R8: Writing the status word clears each flag whose bit (0, 1 or 4) is one in the written value and leaves flags written with zero untouched.
- R9: `irq` is high exactly when some pending flag has its enable bit set; enable word bit 0 enables overflow, bit 1 enables packet end, and bit 4 enables data available.
- R10: The enable word reads back the three enable bits and the level field as last written.
- R11: A push and a data read in the same cycle with the store full both take effect: the oldest byte is returned, the new byte is stored, the count stays at DEPTH and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sampler byte strobe |
| smp_byte | input | DW | Run-length byte from the sampler |
| smp_pkt_end | input | 1 | Sampler end-of-packet pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address: 0 data, 1 enable, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every level setting of a 16-deep configuration against every fill from empty to full. A wrong comparison direction, or an off-by-one at the level, would show up as the data-available bit or `irq` flipping one byte early or late. It also overfills the store and then drains it. A design that overwrote the oldest entry, or that advanced a pointer on the dropped byte, would return a shifted sequence. The bench reads an empty store, then pushes one byte and reads again; a design that popped anyway would return stale data or desynchronize its count. Two more cases are a simultaneous push and pop while full, which a design that tested fullness naively would flag as overflow, and a clear of the data-available flag while above the level, which a design without set priority would leave cleared.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

  localparam int REG_DW = 32;

  // word addresses of the register file
  localparam logic [1:0] ADR_DATA  = 2'd0;
  localparam logic [1:0] ADR_INTEN = 2'd1;
  localparam logic [1:0] ADR_STAT  = 2'd2;

  // flag positions, shared by the enable and status words
  localparam int BIT_OVF   = 0;
  localparam int BIT_PEND  = 1;
  localparam int BIT_AVAIL = 4;
  // lowest bit of the level field and of the count field
  localparam int FIELD_LSB = 8;

  typedef struct packed {
    logic avail;
    logic pend;
    logic ovf;
  } ir_flags_t;

endpackage

// File: rtl/ir_rx_store.sv
module ir_rx_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [CW-1:0] fill,
  output logic [DW-1:0] pop_data,
  output logic          drop
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rd_q;
  logic          full, empty, do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_pop  = pop_req & ~empty;
  assign do_push = push & (~full | do_pop);
  assign drop    = push & full & ~do_pop;

  // storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  // synchronous read port; an empty read yields zero
  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (pop_req) rd_q <= empty ? '0 : mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign fill     = cnt;
  assign pop_data = rd_q;

  a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r4_drop_keeps_full: assert property (@(posedge clk) disable iff (rst)
    drop |=> (cnt == CW'(DEPTH)));
  a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !push) |=> (rd_q == '0 && cnt == '0));
  a_r11_full_swap: assert property (@(posedge clk) disable iff (rst)
    (push && pop_req && full) |=> (cnt == CW'(DEPTH)));

endmodule

// File: rtl/ir_rx_flags.sv
module ir_rx_flags
  import ir_rx_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drop,
  input  logic          pkt_end,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] level,
  input  ir_flags_t     clr,
  input  ir_flags_t     en,
  output ir_flags_t     flags,
  output logic          irq
);

  ir_flags_t pend_q;
  logic      above;

  assign above = (fill > level);

  // a set event in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      pend_q.ovf   <= drop    | (pend_q.ovf   & ~clr.ovf);
      pend_q.pend  <= pkt_end | (pend_q.pend  & ~clr.pend);
      pend_q.avail <= above   | (pend_q.avail & ~clr.avail);
    end
  end

  assign flags = pend_q;
  assign irq   = (pend_q.ovf & en.ovf) | (pend_q.pend & en.pend) |
                 (pend_q.avail & en.avail);

  a_r4_ovf_set: assert property (@(posedge clk) disable iff (rst)
    drop |=> pend_q.ovf);
  a_r6_pend_set: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> pend_q.pend);
  a_r7_avail_set: assert property (@(posedge clk) disable iff (rst)
    above |=> pend_q.avail);
  a_r8_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (clr.ovf && !drop) |=> !pend_q.ovf);
  a_r9_quiet_no_irq: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0) |-> !irq);

endmodule

// File: rtl/ir_rx_regs.sv
module ir_rx_regs
  import ir_rx_pkg::*;
#(
  parameter int CW = 5,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic [CW-1:0]     fill,
  input  ir_flags_t         flags,
  input  logic [DW-1:0]     pop_data,
  output logic              pop_req,
  output ir_flags_t         clr,
  output ir_flags_t         en,
  output logic [CW-1:0]     level,
  output logic [REG_DW-1:0] reg_rdata
);

  logic [REG_DW-1:0] stat_word, inten_word, hold_q;
  logic [1:0]        rsel_q;
  logic              wr_inten, wr_stat;
  logic              unused_wdata;

  assign wr_inten = reg_wr && (reg_addr == ADR_INTEN);
  assign wr_stat  = reg_wr && (reg_addr == ADR_STAT);
  assign pop_req  = reg_rd && (reg_addr == ADR_DATA);

  assign clr.ovf   = wr_stat & reg_wdata[BIT_OVF];
  assign clr.pend  = wr_stat & reg_wdata[BIT_PEND];
  assign clr.avail = wr_stat & reg_wdata[BIT_AVAIL];

  assign unused_wdata = ^{reg_wdata[REG_DW-1:FIELD_LSB+CW], reg_wdata[7:5],
                          reg_wdata[3:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= '0;
      level <= '0;
    end else if (wr_inten) begin
      en.ovf   <= reg_wdata[BIT_OVF];
      en.pend  <= reg_wdata[BIT_PEND];
      en.avail <= reg_wdata[BIT_AVAIL];
      level    <= reg_wdata[FIELD_LSB +: CW];
    end
  end

  always_comb begin
    stat_word                   = '0;
    stat_word[BIT_OVF]          = flags.ovf;
    stat_word[BIT_PEND]         = flags.pend;
    stat_word[BIT_AVAIL]        = flags.avail;
    stat_word[FIELD_LSB +: CW]  = fill;
    inten_word                  = '0;
    inten_word[BIT_OVF]         = en.ovf;
    inten_word[BIT_PEND]        = en.pend;
    inten_word[BIT_AVAIL]       = en.avail;
    inten_word[FIELD_LSB +: CW] = level;
  end

  // snapshot of the addressed word; the data byte lives in the store's read register
  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= ADR_DATA;
      hold_q <= '0;
    end else if (reg_rd) begin
      rsel_q <= reg_addr;
      case (reg_addr)
        ADR_STAT:  hold_q <= stat_word;
        ADR_INTEN: hold_q <= inten_word;
        default:   hold_q <= '0;
      endcase
    end
  end

  assign reg_rdata = (rsel_q == ADR_DATA) ? REG_DW'(pop_data) : hold_q;

  a_r10_level_written: assert property (@(posedge clk) disable iff (rst)
    wr_inten |=> (level == $past(reg_wdata[FIELD_LSB +: CW])));
  a_r2_data_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rsel_q == ADR_DATA) |-> (reg_rdata[REG_DW-1:DW] == '0));

endmodule

// File: rtl/ir_rx_fifo_regs.sv
module ir_rx_fifo_regs
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DW-1:0]     smp_byte,
  input  logic              smp_pkt_end,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq
);

  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] fill, level;
  logic [DW-1:0] pop_data;
  logic          drop, pop_req;
  ir_flags_t     flags, clr, en;

  ir_rx_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (smp_valid),
    .push_data (smp_byte),
    .pop_req   (pop_req),
    .fill      (fill),
    .pop_data  (pop_data),
    .drop      (drop)
  );

  ir_rx_flags #(.CW(CW)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .drop    (drop),
    .pkt_end (smp_pkt_end),
    .fill    (fill),
    .level   (level),
    .clr     (clr),
    .en      (en),
    .flags   (flags),
    .irq     (irq)
  );

  ir_rx_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .fill      (fill),
    .flags     (flags),
    .pop_data  (pop_data),
    .pop_req   (pop_req),
    .clr       (clr),
    .en        (en),
    .level     (level),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: tb/test_ir_rx_fifo_regs.sv
module test_ir_rx_fifo_regs;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_byte = '0;
  logic        smp_pkt_end = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int vecs = 0;
  int bad  = 0;

  always #4 clk = ~clk;

  ir_rx_fifo_regs #(.DEPTH(DEPTH), .DW(8)) i_ir_rx_fifo_regs (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_byte(smp_byte),
    .smp_pkt_end(smp_pkt_end), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); smp_valid = 1'b1; smp_byte = b;
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_all();
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(2'd2, v); chk("R1 status", v, 32'h0);
    rd(2'd1, v); chk("R1 enable", v, 32'h0);
    // R10 enable readback
    wr(2'd1, 32'h0000_0713);
    rd(2'd1, v); chk("R10 enable readback", v, 32'h0000_0713);

    // R2 R3 R7 R9 sweep of every level against every fill
    for (int lvl = 0; lvl < DEPTH; lvl++) begin
      wr(2'd1, (lvl << 8) | 32'h10);
      wr(2'd2, 32'hff);
      for (int n = 0; n <= DEPTH; n++) begin
        if (n > 0) push(8'((lvl * 17 + n) & 8'hff));
        rd(2'd2, v);
        chk("R3 count", (v >> 8) & 32'h1f, n);
        chk("R7 avail bit", (v >> 4) & 32'h1, (n > lvl) ? 1 : 0);
        chk("R9 irq on avail", {31'h0, irq}, (n > lvl) ? 1 : 0);
      end
      // R7 clearing while above level does not stick
      wr(2'd2, 32'h10);
      rd(2'd2, v); chk("R7 avail resets after clear", (v >> 4) & 32'h1, 1);
      for (int i = 1; i <= DEPTH; i++) begin
        rd(2'd0, v);
        chk("R2 data order", v, (lvl * 17 + i) & 32'hff);
      end
      wr(2'd2, 32'hff);
      rd(2'd2, v); chk("R8 clear all after drain", v, 32'h0);
    end

    // R4 overflow
    wr(2'd1, 32'h1);
    for (int i = 0; i < DEPTH; i++) push(8'(8'ha0 + i));
    push(8'hee);
    rd(2'd2, v);
    chk("R4 count stays full", (v >> 8) & 32'h1f, DEPTH);
    chk("R4 overflow bit", v & 32'h1, 1);
    chk("R9 irq on overflow", {31'h0, irq}, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(2'd0, v); chk("R4 contents kept", v, 32'ha0 + i);
    end
    wr(2'd2, 32'h1);
    rd(2'd2, v); chk("R8 overflow cleared", v & 32'h1, 0);
    chk("R9 irq drops", {31'h0, irq}, 0);

    // R5 empty read
    rd(2'd0, v); chk("R5 empty read zero", v, 32'h0);
    rd(2'd2, v); chk("R5 count stays zero", (v >> 8) & 32'h1f, 0);
    push(8'h5c);
    rd(2'd0, v); chk("R5 next byte after empty read", v, 32'h5c);

    // R6 packet end
    wr(2'd2, 32'hff);
    @(negedge clk); smp_pkt_end = 1'b1;
    @(negedge clk); smp_pkt_end = 1'b0;
    rd(2'd2, v); chk("R6 packet-end bit", v & 32'h2, 32'h2);
    chk("R9 irq masked", {31'h0, irq}, 0);
    wr(2'd1, 32'h2);
    @(negedge clk); chk("R9 irq on packet end", {31'h0, irq}, 1);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R8 zero write keeps flag", v & 32'h2, 32'h2);
    wr(2'd2, 32'h2);
    rd(2'd2, v); chk("R8 packet-end cleared", v & 32'h2, 0);

    // R11 simultaneous push and pop while full
    wr(2'd1, 32'h0);
    for (int i = 0; i < DEPTH; i++) push(8'(8'h30 + i));
    wr(2'd2, 32'hff);
    @(negedge clk);
    smp_valid = 1'b1; smp_byte = 8'h99; reg_rd = 1'b1; reg_addr = 2'd0;
    @(negedge clk);
    smp_valid = 1'b0; reg_rd = 1'b0;
    chk("R11 oldest returned", reg_rdata, 32'h30);
    rd(2'd2, v);
    chk("R11 count full", (v >> 8) & 32'h1f, DEPTH);
    chk("R11 no overflow", v & 32'h1, 0);
    for (int i = 1; i < DEPTH; i++) begin
      rd(2'd0, v); chk("R11 drain order", v, 32'h30 + i);
    end
    rd(2'd0, v); chk("R11 new byte stored", v, 32'h99);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        vecs++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule